// File: doc/BRIEF.md
# Bus Clock-High Timeout Detector

This block guards a two-wire serial bus against a clock line that stays high for too long while a transfer is in progress. It brings the clock line level into the system clock domain through a two-flop synchronizer. While the bus is marked busy, it counts how many consecutive system-clock cycles the synchronized clock level stays high. When that run grows longer than the selected limit, it sets a sticky timeout flag and emits a one-cycle interrupt request.

Two limits are built in as parameters: a long one and a short one. A select input chooses between them at run time. Detection works only while the detect-enable input is high. The flag has no write path. It goes back to zero only when the surrounding interface is disabled or sent a reset command. Register decode, the rest of the bus controller and the interrupt controller sit outside this block.

Top module: `sclHighWatch`

## Requirements
- R1: After reset, timeoutFlag and timeoutIrq are 0.
- R2: With busBusy and detectEn high, timeoutFlag sets once the synchronized clock level has been high for more than the selected limit of consecutive cycles. A high run of at most the limit never sets it.
- R3: selectShort = 0 selects LONG_LIMIT and selectShort = 1 selects SHORT_LIMIT as the limit.
- R4: While detectEn is 0, timeoutFlag never sets and no interrupt pulse is produced.
- R5: A cycle with the synchronized clock low, or with busBusy low, restarts the high-run count from zero.
- R6: Once set, timeoutFlag stays 1 whatever the bus does, until it is cleared. A clock level that stays high after the flag is set raises no further interrupt pulse.
- R7: ifEnable = 0 clears timeoutFlag at the next clock edge and restarts the count. The clear wins over a set in the same cycle.
- R8: ifReset = 1 clears timeoutFlag at the next clock edge and restarts the count.
- R9: timeoutIrq is a single-cycle pulse that rises at the same edge at which timeoutFlag rises.
- R10: sclIn passes through two synchronizer flops. With busBusy and detectEn already high, sclIn going high just before edge 1 makes timeoutFlag rise at edge limit+3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busBusy | input | 1 | High while a transfer occupies the bus |
| sclIn | input | 1 | Raw bus clock line level |
| detectEn | input | 1 | Enables timeout detection |
| selectShort | input | 1 | 0: long limit, 1: short limit |
| ifEnable | input | 1 | Interface enable; 0 clears the flag |
| ifReset | input | 1 | Interface reset command; 1 clears the flag |
| timeoutFlag | output | 1 | Sticky timeout flag, read-only |
| timeoutIrq | output | 1 | One-cycle interrupt request pulse |

## Verification
A raw clock level that goes high just before edge 1 reaches the counter at edge 3. The flag and the interrupt pulse then rise together at edge limit+3, and the pulse falls at edge limit+4. The clear commands act at the very next edge. The bench drives every input on a falling edge and samples on the falling edges that follow, so it checks each result exactly half a cycle after the rising edge at which it is due. For the pulse-length sweep, the bench waits out the synchronizer delay before it compares the final flag state and the number of interrupt pulses with the arithmetic outcome (length greater than limit).

// File: rtl/sclWatchPkg.sv
package sclWatchPkg;
  // strobes from control to the run counter
  typedef struct packed {
    logic clrRun;   // restart the high-run count
    logic advRun;   // count one more high cycle
  } runStrobes_t;
endpackage

// File: rtl/sclWatchDatapath.sv
module sclWatchDatapath
  import sclWatchPkg::*;
#(
  parameter int LONG_LIMIT  = 4096,
  parameter int SHORT_LIMIT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        selectShort,
  input  runStrobes_t strb,
  output logic        sclSync,
  output logic        limitReached
);
  localparam int CNT_W = $clog2(LONG_LIMIT + 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_LIMIT);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_LIMIT);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       runCnt;
  logic [CNT_W-1:0]       activeLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], sclIn};
  end
  assign sclSync = syncChain[SYNC_STAGES-1];

  assign activeLimit = selectShort ? SHORT_LIM : LONG_LIM;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            runCnt <= '0;
    else if (strb.clrRun) runCnt <= '0;
    else if (strb.advRun) runCnt <= runCnt + 1'b1;
  end

  assign limitReached = (runCnt >= activeLimit);

  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRun |=> (runCnt == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LONG_LIM);
endmodule

// File: rtl/sclWatchCtrl.sv
module sclWatchCtrl
  import sclWatchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busBusy,
  input  logic        sclSync,
  input  logic        detectEn,
  input  logic        ifEnable,
  input  logic        ifReset,
  input  logic        limitReached,
  output runStrobes_t strb,
  output logic        timeoutFlag,
  output logic        timeoutIrq
);
  logic clearCmd;
  logic setNow;

  assign clearCmd    = !ifEnable || ifReset;
  assign strb.clrRun = clearCmd || !detectEn || !busBusy || !sclSync;
  assign strb.advRun = !strb.clrRun && !timeoutFlag && !limitReached;
  assign setNow      = !strb.clrRun && !timeoutFlag && limitReached;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
      timeoutIrq  <= 1'b0;
    end else begin
      timeoutIrq <= setNow;
      if (clearCmd)    timeoutFlag <= 1'b0;
      else if (setNow) timeoutFlag <= 1'b1;
    end
  end

  // R4
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!detectEn && !timeoutFlag) |=> !timeoutFlag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && ifEnable && !ifReset) |=> timeoutFlag);

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> !timeoutFlag);

  // R8
  reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |=> !timeoutFlag);

  // R9
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> timeoutFlag);

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |=> !timeoutIrq);
endmodule

// File: rtl/sclHighWatch.sv
module sclHighWatch
  import sclWatchPkg::*;
#(
  parameter int LONG_LIMIT  = 4096,
  parameter int SHORT_LIMIT = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic busBusy,
  input  logic sclIn,
  input  logic detectEn,
  input  logic selectShort,
  input  logic ifEnable,
  input  logic ifReset,
  output logic timeoutFlag,
  output logic timeoutIrq
);
  runStrobes_t strb;
  logic        sclSync;
  logic        limitReached;

  sclWatchDatapath #(
    .LONG_LIMIT (LONG_LIMIT),
    .SHORT_LIMIT(SHORT_LIMIT),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .selectShort (selectShort),
    .strb        (strb),
    .sclSync     (sclSync),
    .limitReached(limitReached)
  );

  sclWatchCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busBusy     (busBusy),
    .sclSync     (sclSync),
    .detectEn    (detectEn),
    .ifEnable    (ifEnable),
    .ifReset     (ifReset),
    .limitReached(limitReached),
    .strb        (strb),
    .timeoutFlag (timeoutFlag),
    .timeoutIrq  (timeoutIrq)
  );
endmodule

// File: tb/sclHighWatch_tb.sv
`timescale 1ns/1ps
module sclHighWatch_tb;
  localparam int LONG_L  = 12;
  localparam int SHORT_L = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busBusy = 1'b0, sclIn = 1'b0, detectEn = 1'b0, selectShort = 1'b0;
  logic ifEnable = 1'b1, ifReset = 1'b0;
  logic timeoutFlag, timeoutIrq;

  int checks = 0, fails = 0, irqSeen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclHighWatch #(.LONG_LIMIT(LONG_L), .SHORT_LIMIT(SHORT_L)) u_dut (
    .clk(clk), .rstN(rstN), .busBusy(busBusy), .sclIn(sclIn),
    .detectEn(detectEn), .selectShort(selectShort), .ifEnable(ifEnable),
    .ifReset(ifReset), .timeoutFlag(timeoutFlag), .timeoutIrq(timeoutIrq));

  always @(negedge clk) if (rstN && timeoutIrq) irqSeen++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearAll();
    ifReset = 1'b1; sclIn = 1'b0; waitN(1);
    ifReset = 1'b0; waitN(3);
    irqSeen = 0;
  endtask

  initial begin
    waitN(2);
    check(timeoutFlag == 1'b0, "R1 flag after reset", int'(timeoutFlag), 0);
    check(timeoutIrq == 1'b0, "R1 irq after reset", int'(timeoutIrq), 0);
    rstN = 1'b1;
    busBusy = 1'b1; detectEn = 1'b1;
    waitN(2);

    // R2 R3 sweep of pulse lengths for both limit choices
    for (int sel = 0; sel < 2; sel++) begin
      int lim;
      lim = sel ? SHORT_L : LONG_L;
      selectShort = sel[0];
      for (int len = 1; len <= lim + 3; len++) begin
        int expF;
        clearAll();
        sclIn = 1'b1; waitN(len);
        sclIn = 1'b0; waitN(4);
        expF = (len > lim) ? 1 : 0;
        check(int'(timeoutFlag) == expF, sel ? "R3 R2 short-limit flag" : "R3 R2 long-limit flag",
              int'(timeoutFlag), expF);
        check(irqSeen == expF, "R9 irq count in sweep", irqSeen, expF);
      end
    end

    // R10 R9 exact latency with the long limit
    selectShort = 1'b0;
    clearAll();
    sclIn = 1'b1; waitN(LONG_L + 2);
    check(timeoutFlag == 1'b0, "R10 flag not early", int'(timeoutFlag), 0);
    waitN(1);
    check(timeoutFlag == 1'b1, "R10 flag at limit+3", int'(timeoutFlag), 1);
    check(timeoutIrq == 1'b1, "R9 irq with flag", int'(timeoutIrq), 1);
    waitN(1);
    check(timeoutIrq == 1'b0, "R9 irq one cycle", int'(timeoutIrq), 0);
    // R6 stays set, no second pulse while high persists
    waitN(LONG_L + 5);
    sclIn = 1'b0; busBusy = 1'b0; waitN(5);
    check(timeoutFlag == 1'b1, "R6 flag sticky", int'(timeoutFlag), 1);
    check(irqSeen == 1, "R6 single irq", irqSeen, 1);

    // R7 interface disable clears, wins over set
    busBusy = 1'b1; sclIn = 1'b1; waitN(3);
    ifEnable = 1'b0; waitN(1);
    check(timeoutFlag == 1'b0, "R7 disable clears", int'(timeoutFlag), 0);
    ifEnable = 1'b1; waitN(1);
    check(timeoutFlag == 1'b0, "R7 count restarted", int'(timeoutFlag), 0);
    waitN(LONG_L);
    check(timeoutFlag == 1'b1, "R7 sets again after full run", int'(timeoutFlag), 1);

    // R8 reset command clears
    ifReset = 1'b1; waitN(1);
    check(timeoutFlag == 1'b0, "R8 reset command clears", int'(timeoutFlag), 0);
    ifReset = 1'b0; waitN(LONG_L);
    check(timeoutFlag == 1'b0, "R8 count restarted", int'(timeoutFlag), 0);
    waitN(1);
    check(timeoutFlag == 1'b1, "R8 sets after limit+1 cycles", int'(timeoutFlag), 1);

    // R5 busy drop restarts the run
    clearAll();
    busBusy = 1'b0; sclIn = 1'b1; waitN(4);
    busBusy = 1'b1; waitN(LONG_L);
    busBusy = 1'b0; waitN(2);
    busBusy = 1'b1; waitN(LONG_L);
    busBusy = 1'b0; waitN(2);
    check(timeoutFlag == 1'b0, "R5 busy drop restarts", int'(timeoutFlag), 0);
    busBusy = 1'b1; waitN(LONG_L + 1);
    check(timeoutFlag == 1'b1, "R5 full busy run sets", int'(timeoutFlag), 1);

    // R5 short low glitch on the clock restarts the run
    clearAll();
    sclIn = 1'b1; waitN(LONG_L);
    sclIn = 1'b0; waitN(1);
    sclIn = 1'b1; waitN(LONG_L);
    sclIn = 1'b0; waitN(4);
    check(timeoutFlag == 1'b0, "R5 low cycle restarts", int'(timeoutFlag), 0);

    // R4 detection off
    clearAll();
    detectEn = 1'b0; sclIn = 1'b1; waitN(LONG_L + 10);
    check(timeoutFlag == 1'b0, "R4 no flag when disabled", int'(timeoutFlag), 0);
    check(irqSeen == 0, "R4 no irq when disabled", irqSeen, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        waitN(20000);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule